// File: doc/BRIEF.md
# Byte-Lane Odd Parity Guard

This block protects a 64-bit data bus with one parity bit per byte lane, using odd parity. On the outgoing side it produces eight parity bits from the write data in the same cycle. The bus interface drives those bits next to the data. On the incoming side it takes each read beat with its eight received parity bits and checks every lane. Any failing lane is reported to the exception logic as a one-cycle strobe, a per-lane error vector, and a request for either a machine check or a checkstop.

A read beat counts only in a cycle where the transfer acknowledge is high and the transfer is a read. This acknowledge is the valid qualifier for the incoming stream. The guard can always take a beat, so it applies no back-pressure and has no ready output. The bus side may hold back the acknowledge for any number of cycles; beats that are not acknowledged are ignored.

A configuration input turns checking off completely. A second configuration input chooses which exception request a parity error raises. Both are sampled with the beat they apply to.

Top module: `byte_parity_guard`

## Requirements
- R1: In every cycle, `wr_par[i]` is set so that byte lane i of `wr_data` together with `wr_par[i]` holds an odd number of ones. This output is combinational, with no register delay.
- R2: Byte lane i covers data bits [8i+7:8i] and parity bit i, for lanes 0 to 7.
- R3: A beat is an accepted read beat when `xfer_ack`=1, `xfer_rd`=1 and `cfg_chk_off`=0. On such a beat, a lane whose byte plus received parity bit holds an even number of ones is in error. Its bit in `perr_lanes` is 1 in the cycle after that beat.
- R4: A beat with `xfer_ack`=0 produces no error report in the following cycle, whatever its data and parity.
- R5: `perr_pulse` is high for exactly the one cycle after each accepted read beat that has at least one failing lane. `perr_lanes` is all zeros whenever `perr_pulse` is low.
- R6: When `cfg_chk_off`=1 during a beat, that beat produces no error report.
- R7: A beat with `xfer_rd`=0 (a write) never produces an error report.
- R8: During an error report, the value of `cfg_sev` at the beat selects the request. 0 raises `mchk_req` and 1 raises `chkstop_req`. At most one request is high, and a request is high only together with `perr_pulse`.
- R9: While `rst_n` is low, `perr_pulse`, `perr_lanes`, `mchk_req` and `chkstop_req` are all 0.
- R10: An accepted read beat whose eight lanes all hold odd parity produces no error report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chk_off | input | 1 | 1 turns off read parity checking |
| cfg_sev | input | 1 | Error response select: 0 machine check, 1 checkstop |
| wr_data | input | 64 | Outgoing write data |
| wr_par | output | 8 | Odd parity per byte lane of wr_data |
| rd_data | input | 64 | Incoming read data |
| rd_par | input | 8 | Received parity per byte lane |
| xfer_ack | input | 1 | Transfer acknowledge; qualifies a data beat |
| xfer_rd | input | 1 | 1 when the current transfer is a read |
| perr_pulse | output | 1 | One-cycle data parity error strobe |
| perr_lanes | output | 8 | Failing byte lanes of the reported beat |
| mchk_req | output | 1 | Machine check request |
| chkstop_req | output | 1 | Checkstop request |

## Verification
The bench sweeps all 256 values of each byte lane through the generator, so a flipped parity sense or a swapped lane shows up at once. On the read side it drives all 256 combinations of corrupted parity bits back to back. It also flips each of the 64 data bits one at a time. A design that maps lanes wrongly, misses consecutive error beats, or leaves a stale vector after the strobe would report the wrong lanes. Beats that are not acknowledged, write beats, and beats with checking turned off all carry bad parity. A design that forgets any of these qualifiers raises a false strobe. The severity input alternates from beat to beat, so a design that latches it at the wrong cycle raises the wrong request.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  typedef enum logic {
    SEV_MCHK    = 1'b0,
    SEV_CHKSTOP = 1'b1
  } sev_e;

endpackage

// File: rtl/bpc_lane_par.sv
module bpc_lane_par #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] bits_i,
  output logic              odd_o
);
  // bit that makes bits_i plus itself hold an odd count of ones
  assign odd_o = ~(^bits_i);
endmodule

// File: rtl/bpc_gen.sv
module bpc_gen #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic [BUS_W-1:0] data_i,
  output logic [LANES-1:0] par_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bpc_lane_par #(.LANE_W(LANE_W)) u_cell (
      .bits_i(data_i[g*LANE_W +: LANE_W]),
      .odd_o (par_o[g])
    );
  end
endmodule

// File: rtl/bpc_chk.sv
module bpc_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic             beat_ok_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic [LANES-1:0] par_i,
  output logic [LANES-1:0] bad_o
);
  logic [LANES-1:0] want;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bpc_lane_par #(.LANE_W(LANE_W)) u_cell (
      .bits_i(data_i[g*LANE_W +: LANE_W]),
      .odd_o (want[g])
    );
    assign bad_o[g] = beat_ok_i & (want[g] ^ par_i[g]);
  end
endmodule

// File: rtl/bpc_report.sv
module bpc_report
  import bpc_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] bad_i,
  input  logic             sev_i,
  output logic             pulse_o,
  output logic [LANES-1:0] lanes_o,
  output logic             mchk_o,
  output logic             chkstop_o
);
  logic [LANES-1:0] lanes_q;
  logic             pulse_q;
  sev_e             sev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lanes_q <= '0;
      pulse_q <= 1'b0;
      sev_q   <= SEV_MCHK;
    end else begin
      lanes_q <= bad_i;
      pulse_q <= |bad_i;
      sev_q   <= sev_e'(sev_i);
    end
  end

  assign pulse_o   = pulse_q;
  assign lanes_o   = lanes_q;
  assign mchk_o    = pulse_q & (sev_q == SEV_MCHK);
  assign chkstop_o = pulse_q & (sev_q == SEV_CHKSTOP);
endmodule

// File: rtl/byte_parity_guard.sv
module byte_parity_guard #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_chk_off,
  input  logic             cfg_sev,
  input  logic [BUS_W-1:0] wr_data,
  output logic [LANES-1:0] wr_par,
  input  logic [BUS_W-1:0] rd_data,
  input  logic [LANES-1:0] rd_par,
  input  logic             xfer_ack,
  input  logic             xfer_rd,
  output logic             perr_pulse,
  output logic [LANES-1:0] perr_lanes,
  output logic             mchk_req,
  output logic             chkstop_req
);
  logic             beat_ok;
  logic [LANES-1:0] lane_bad;

  // only acknowledged read beats with checking enabled are examined
  assign beat_ok = xfer_ack & xfer_rd & ~cfg_chk_off;

  bpc_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen (
    .data_i(wr_data),
    .par_o (wr_par)
  );

  bpc_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .beat_ok_i(beat_ok),
    .data_i   (rd_data),
    .par_i    (rd_par),
    .bad_o    (lane_bad)
  );

  bpc_report #(.LANES(LANES)) u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .bad_i    (lane_bad),
    .sev_i    (cfg_sev),
    .pulse_o  (perr_pulse),
    .lanes_o  (perr_lanes),
    .mchk_o   (mchk_req),
    .chkstop_o(chkstop_req)
  );
endmodule

// File: rtl/bpc_guard_sva.sv
module bpc_guard_sva #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_chk_off,
  input logic             cfg_sev,
  input logic [BUS_W-1:0] wr_data,
  input logic [LANES-1:0] wr_par,
  input logic             xfer_ack,
  input logic             xfer_rd,
  input logic             perr_pulse,
  input logic [LANES-1:0] perr_lanes,
  input logic             mchk_req,
  input logic             chkstop_req
);
  // R1: every lane odd, so the whole word plus parity holds an even count
  a_r1_wr_total_even: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_data, wr_par}) % 2 == 0);

  // R4: no acknowledge, no report
  a_r4_no_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ack |=> !perr_pulse);

  // R5: vector only during the strobe, strobe only with a lane marked
  a_r5_lanes_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    perr_pulse == (perr_lanes != '0));

  // R6: checking turned off
  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chk_off |=> !perr_pulse);

  // R7: writes never report
  a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_rd |=> !perr_pulse);

  // R8: one request at most, tied to the strobe
  a_r8_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mchk_req, chkstop_req}) && (perr_pulse == (mchk_req | chkstop_req)));

  // R8: request follows the severity present at the beat
  a_r8_sev_follows: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> (!perr_pulse || (chkstop_req == $past(cfg_sev))));

  // R9: reset holds reports low
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!perr_pulse && !mchk_req && !chkstop_req) || !rst_n);
endmodule

bind byte_parity_guard bpc_guard_sva #(.LANES(LANES), .LANE_W(LANE_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_chk_off(cfg_chk_off),
  .cfg_sev    (cfg_sev),
  .wr_data    (wr_data),
  .wr_par     (wr_par),
  .xfer_ack   (xfer_ack),
  .xfer_rd    (xfer_rd),
  .perr_pulse (perr_pulse),
  .perr_lanes (perr_lanes),
  .mchk_req   (mchk_req),
  .chkstop_req(chkstop_req)
);

// File: tb/tb_byte_parity_guard.sv
module tb_byte_parity_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_chk_off = 1'b0;
  logic        cfg_sev = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_par;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_par = '0;
  logic        xfer_ack = 1'b0;
  logic        xfer_rd = 1'b0;
  logic        perr_pulse;
  logic [7:0]  perr_lanes;
  logic        mchk_req;
  logic        chkstop_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_parity_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_chk_off(cfg_chk_off), .cfg_sev(cfg_sev),
    .wr_data(wr_data), .wr_par(wr_par), .rd_data(rd_data), .rd_par(rd_par),
    .xfer_ack(xfer_ack), .xfer_rd(xfer_rd), .perr_pulse(perr_pulse),
    .perr_lanes(perr_lanes), .mchk_req(mchk_req), .chkstop_req(chkstop_req)
  );

  // odd parity per byte, computed by counting ones
  function automatic logic [7:0] odd_par(input logic [63:0] d);
    logic [7:0] p;
    for (int l = 0; l < 8; l++) begin
      int n = 0;
      for (int b = 0; b < 8; b++) n += d[8*l+b];
      p[l] = (n % 2 == 0);
    end
    return p;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report_chk(input string req, input logic [7:0] exp_lanes, input logic sev);
    logic ep;
    ep = (exp_lanes != 8'h00);
    chk({req, " lanes"}, {56'h0, perr_lanes}, {56'h0, exp_lanes});
    chk({req, " pulse"}, {63'h0, perr_pulse}, {63'h0, ep});
    chk({req, " R8 mchk"}, {63'h0, mchk_req}, {63'h0, ep & ~sev});
    chk({req, " R8 chkstop"}, {63'h0, chkstop_req}, {63'h0, ep & sev});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  g;
    // R9: reset with a bad read beat on the bus
    xfer_ack = 1'b1; xfer_rd = 1'b1; rd_data = 64'h1; rd_par = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9 pulse", {63'h0, perr_pulse}, 64'h0);
    chk("R9 lanes", {56'h0, perr_lanes}, 64'h0);
    chk("R9 requests", {62'h0, mchk_req, chkstop_req}, 64'h0);
    xfer_ack = 1'b0;
    rst_n = 1'b1;
    step();

    // R1/R2: every byte value in every lane
    for (int v = 0; v < 256; v++) begin
      for (int l = 0; l < 8; l++) wr_data[8*l +: 8] = 8'(v + 29 * l);
      #1;
      chk("R1 R2 write parity", {56'h0, wr_par}, {56'h0, odd_par(wr_data)});
    end

    // R3/R5/R8/R10: all corruption masks, back to back beats
    xfer_ack = 1'b1; xfer_rd = 1'b1;
    for (int m = 0; m < 256; m++) begin
      logic sev_now;
      d = {8{8'(m * 7 + 3)}} ^ (64'h0123_4567_89ab_cdef << (m % 5));
      sev_now = m[0] ^ m[3];
      rd_data = d; rd_par = odd_par(d) ^ 8'(m); cfg_sev = sev_now;
      step();
      report_chk(m == 0 ? "R10 clean beat" : "R3 R5 parity mask", 8'(m), sev_now);
    end

    // R2/R3: single data bit flips
    for (int j = 0; j < 64; j++) begin
      d = 64'hfedc_ba98_7654_3210;
      g = odd_par(d);
      rd_data = d ^ (64'h1 << j); rd_par = g; cfg_sev = 1'b1;
      step();
      report_chk("R2 R3 data flip", 8'h1 << (j / 8), 1'b1);
    end

    // R5: strobe lasts one cycle
    rd_data = 64'h0; rd_par = 8'h00; cfg_sev = 1'b0;
    step();
    report_chk("R5 first", 8'hff, 1'b0);
    xfer_ack = 1'b0;
    step();
    report_chk("R5 after", 8'h00, 1'b0);

    // R4: unacknowledged bad beats
    for (int k = 0; k < 4; k++) begin
      rd_data = 64'(k); rd_par = 8'h00;
      step();
      report_chk("R4 no ack", 8'h00, 1'b0);
    end

    // R7: acknowledged write beats with bad parity
    xfer_ack = 1'b1; xfer_rd = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rd_data = 64'(k * 3); rd_par = 8'h00;
      step();
      report_chk("R7 write beat", 8'h00, 1'b0);
    end

    // R6: checking turned off
    xfer_rd = 1'b1; cfg_chk_off = 1'b1;
    for (int k = 0; k < 4; k++) begin
      rd_data = 64'(k * 5); rd_par = 8'h00;
      step();
      report_chk("R6 check off", 8'h00, 1'b0);
    end
    cfg_chk_off = 1'b0;
    rd_data = 64'h0; rd_par = 8'h0f; cfg_sev = 1'b1;
    step();
    report_chk("R6 re-enabled", 8'hf0, 1'b1);
    xfer_ack = 1'b0;
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule